// File: doc/BRIEF.md
# Power-Good and Fault Supervisor

This block is the clocked supervisory logic of a multiphase regulator controller. Analog comparators outside the block report seven conditions as flags: the logic supply is under voltage, the driver supply is under voltage, the output is under the power-good level, the output is over the overvoltage limit, the load current is too high, the compensation node is above the startup offset, and the compensation node is under the discharge level. A flag from an external capacitor timer reports that the programmable delay is done. Every one of these flags goes through a two-flop synchronizer before the block uses it.

The block holds a fault latch. Undervoltage on either supply sets it, and so do overvoltage and overcurrent. Only a completed undervoltage episode clears it. The block enables switching once the compensation node has passed its startup offset. It disables switching when the node falls under the discharge level. It forces all gates low while a fault is present. Power-good stays pulled down until the output enters its window during start-up. It is then released only after both delays have run out: the fixed internal delay and the external delay, which the block starts with a one-cycle pulse. The fixed delay length is set from the clock frequency and the delay in microseconds.

Top module: `pg_fault_supervisor`

## Requirements
- R1: After reset, pg_pull is 1, sw_en is 0, gate_low is 0 and xdly_start is 0.
- R2: When uv_logic or uv_drive is 1, gate_low becomes 1, sw_en becomes 0 and pg_pull becomes 1 within two clock cycles, through the synchronizer.
- R3: A 1 on vout_high or ocp sets the fault latch. gate_low then stays 1 and sw_en stays 0 after the flag returns to 0.
- R4: The fault latch clears only in the cycle after the synchronized undervoltage condition drops to 0. Compensation flags and cleared fault flags do not clear it. If an overvoltage or overcurrent flag is present in that same cycle, the latch stays set.
- R5: sw_en rises exactly three cycles after comp_start rises, when there is no fault and comp_dis is 0. It stays 1 after comp_start drops back to 0.
- R6: comp_dis=1 drives sw_en to 0 within two cycles. Switching does not resume until comp_start is seen again.
- R7: pg_pull is 1 whenever vout_low or vout_high is 1, after two cycles of synchronizer latency. After the power-good release, leaving and re-entering the window needs no new delay.
- R8: While switching and not yet released, entering the output window produces a single-cycle xdly_start pulse three cycles after vout_low falls. Leaving the window before release resets both delays, and the next entry produces a new pulse.
- R9: If xdly_done is already 1, pg_pull falls exactly FIX_CNT+1 cycles after the xdly_start pulse. FIX_CNT is CLK_HZ/1e6*DLY_US.
- R10: If xdly_done rises after the fixed delay has expired, pg_pull stays 1 until then and falls three cycles after xdly_done rises.
- R11: When switching stops or undervoltage occurs, the power-good release is withdrawn. The next start-up issues a new xdly_start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uv_logic | input | 1 | Logic supply below its turn-off level |
| uv_drive | input | 1 | Driver supply below its turn-off level |
| vout_low | input | 1 | Output below the power-good level |
| vout_high | input | 1 | Output above the overvoltage limit |
| ocp | input | 1 | Overcurrent detected |
| comp_start | input | 1 | Compensation node above the startup offset |
| comp_dis | input | 1 | Compensation node below the discharge level |
| xdly_done | input | 1 | External programmable delay has expired |
| sw_en | output | 1 | Switching enable |
| gate_low | output | 1 | Force all gate outputs low |
| pg_pull | output | 1 | Request to pull the open-drain power-good pin low |
| xdly_start | output | 1 | One-cycle pulse that starts the external delay |

## Verification
Two things can happen in the same cycle: setting the fault latch through overcurrent, and clearing it because undervoltage has ended. Both flags pass through the same synchronizer depth. The bench therefore provokes the clash by dropping uv_drive and raising ocp on the same falling edge. It then checks that gate_low stays 1, because setting wins, and that it stays 1 after ocp is removed. The random phase also produces such overlaps. It judges gate_low against a latch model that the bench updates once per held input segment.

// File: rtl/pg_fault_supervisor.sv
module pg_fault_supervisor #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned DLY_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_logic,
  input  logic uv_drive,
  input  logic vout_low,
  input  logic vout_high,
  input  logic ocp,
  input  logic comp_start,
  input  logic comp_dis,
  input  logic xdly_done,
  output logic sw_en,
  output logic gate_low,
  output logic pg_pull,
  output logic xdly_start
);
  localparam int unsigned FIX_CNT = (CLK_HZ / 1_000_000) * DLY_US;
  localparam int unsigned CW = $clog2(FIX_CNT + 1);
  localparam int unsigned NF = 8;

  logic [NF-1:0] raw, s1, s2;
  assign raw = {xdly_done, comp_dis, comp_start, ocp, vout_high, vout_low, uv_drive, uv_logic};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  logic uvlo, ovr, ocr, cmp_hi, cmp_lo, xdone, window;
  assign uvlo   = s2[0] | s2[1];
  assign window = ~s2[2] & ~s2[3];
  assign ovr    = s2[3];
  assign ocr    = s2[4];
  assign cmp_hi = s2[5];
  assign cmp_lo = s2[6];
  assign xdone  = s2[7];

  logic fault_q, uvlo_d, run_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fault_q <= 1'b0;
      uvlo_d  <= 1'b0;
    end else begin
      uvlo_d <= uvlo;
      if (uvlo | ovr | ocr) fault_q <= 1'b1;
      else if (uvlo_d & ~uvlo) fault_q <= 1'b0;
    end

  assign gate_low = fault_q | uvlo;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run_q <= 1'b0;
    else run_q <= ~(gate_low | cmp_lo) & (run_q | cmp_hi);

  assign sw_en = run_q & ~gate_low & ~cmp_lo;

  logic          tmr_act, xseen, pg_rel, start_c, xstart_q;
  logic [CW-1:0] cnt;
  assign start_c = run_q & ~pg_rel & window & ~tmr_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmr_act <= 1'b0;
      cnt     <= '0;
      xseen   <= 1'b0;
    end else if (~window | ~run_q | pg_rel) begin
      tmr_act <= 1'b0;
      cnt     <= '0;
      xseen   <= 1'b0;
    end else if (~tmr_act) begin
      tmr_act <= 1'b1;
      cnt     <= '0;
      xseen   <= 1'b0;
    end else begin
      if (cnt != CW'(FIX_CNT)) cnt <= cnt + 1'b1;
      if (xdone) xseen <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pg_rel   <= 1'b0;
      xstart_q <= 1'b0;
    end else begin
      xstart_q <= start_c;
      if (uvlo | ~run_q) pg_rel <= 1'b0;
      else if (tmr_act & window & (cnt == CW'(FIX_CNT)) & (xseen | xdone)) pg_rel <= 1'b1;
    end

  assign xdly_start = xstart_q;
  assign pg_pull    = ~pg_rel | uvlo | ~window;

  a_r3_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr | ocr) |=> fault_q);
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !$fell(uvlo)) |=> fault_q);
  a_r5_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> $past(cmp_hi));
  a_r6_discharge: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_lo |=> !run_q);
  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xdly_start |=> !xdly_start);
  a_r9_fixed_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_rel) |-> ($past(cnt) == CW'(FIX_CNT)));
  a_r11_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo | !run_q) |=> !pg_rel);
endmodule

// File: tb/pg_fault_supervisor_tb.sv
module pg_fault_supervisor_tb;
  localparam int CLK_P = 10;
  localparam int FIX = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic uv_logic = 0, uv_drive = 0, vout_low = 1, vout_high = 0, ocp = 0;
  logic comp_start = 0, comp_dis = 0, xdly_done = 0;
  logic sw_en, gate_low, pg_pull, xdly_start;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pg_fault_supervisor #(.CLK_HZ(1_000_000), .DLY_US(FIX)) u_dut (
    .clk(clk), .rst_n(rst_n), .uv_logic(uv_logic), .uv_drive(uv_drive),
    .vout_low(vout_low), .vout_high(vout_high), .ocp(ocp),
    .comp_start(comp_start), .comp_dis(comp_dis), .xdly_done(xdly_done),
    .sw_en(sw_en), .gate_low(gate_low), .pg_pull(pg_pull), .xdly_start(xdly_start));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic wait_pulse(input string tag, output int n);
    n = 0;
    while (!xdly_start && n < 40) begin tick(1); n++; end
    chk(xdly_start == 1'b1, tag, xdly_start, 1);
  endtask

  task automatic count_release(output int n);
    n = 0;
    while (pg_pull && n < 200) begin tick(1); n++; end
  endtask

  function automatic bit exp_fault(bit cur, bit prev_uv, bit uv, bit ov, bit oc);
    if (uv | ov | oc) return 1'b1;
    if (prev_uv & ~uv) return 1'b0;
    return cur;
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    bit fexp, puv;
    tick(3);
    eq("R1 pg_pull", pg_pull, 1);
    eq("R1 sw_en", sw_en, 0);
    eq("R1 gate_low", gate_low, 0);
    eq("R1 xdly_start", xdly_start, 0);
    rst_n = 1'b1;
    tick(6);
    eq("R5 no start without offset", sw_en, 0);
    comp_start = 1;
    tick(2);
    eq("R5 sw_en before 3 cycles", sw_en, 0);
    tick(1);
    eq("R5 sw_en at 3 cycles", sw_en, 1);
    comp_start = 0;
    tick(5);
    eq("R5 sw_en held", sw_en, 1);

    xdly_done = 1;
    vout_low = 0;
    tick(2);
    eq("R8 no pulse early", xdly_start, 0);
    tick(1);
    eq("R8 pulse at 3 cycles", xdly_start, 1);
    tick(1);
    eq("R8 pulse one cycle", xdly_start, 0);
    count_release(n);
    eq("R9 release delay", n + 1, FIX + 1);

    vout_low = 1;
    tick(2);
    eq("R7 pg low on undervoltage", pg_pull, 1);
    vout_low = 0;
    tick(2);
    eq("R7 release kept", pg_pull, 0);

    ocp = 1;
    tick(3);
    eq("R3 gate_low", gate_low, 1);
    eq("R3 sw_en", sw_en, 0);
    ocp = 0;
    comp_start = 1;
    tick(6);
    eq("R3 latch sticky", gate_low, 1);
    eq("R4 comp no clear", sw_en, 0);
    eq("R11 pg withdrawn", pg_pull, 1);

    uv_drive = 1;
    tick(2);
    eq("R2 gate_low", gate_low, 1);
    eq("R2 pg_pull", pg_pull, 1);
    eq("R2 sw_en", sw_en, 0);
    tick(3);
    uv_drive = 0;
    ocp = 1;
    tick(5);
    eq("R4 set wins over clear", gate_low, 1);
    ocp = 0;
    tick(5);
    eq("R4 still set", gate_low, 1);
    uv_logic = 1;
    tick(4);
    uv_logic = 0;
    tick(3);
    eq("R4 cleared by uvlo end", gate_low, 0);
    wait_pulse("R11 new pulse after restart", n);
    count_release(n);
    eq("R9 release after restart", n, FIX + 1);

    xdly_done = 0;
    comp_dis = 1;
    comp_start = 0;
    tick(2);
    eq("R6 sw_en off", sw_en, 0);
    tick(3);
    comp_dis = 0;
    tick(6);
    eq("R6 no resume", sw_en, 0);
    comp_start = 1;
    wait_pulse("R8 pulse on restart", n);
    tick(FIX + 10);
    eq("R10 held without ext done", pg_pull, 1);
    xdly_done = 1;
    count_release(n);
    eq("R10 release after ext done", n, 3);

    comp_dis = 1;
    tick(4);
    comp_dis = 0;
    wait_pulse("R8 pulse again", n);
    tick(5);
    vout_low = 1;
    tick(4);
    vout_low = 0;
    wait_pulse("R8 second pulse after window loss", n);
    count_release(n);
    eq("R8 timers restarted", n, FIX + 1);

    void'($urandom(32'd7));
    fexp = 0;
    puv = 0;
    for (int s = 0; s < 400; s++) begin
      bit ul, ud, ol, oh, oc, ch, cl;
      ul = ($urandom_range(0, 9) == 0);
      ud = ($urandom_range(0, 9) == 0);
      ol = ($urandom_range(0, 3) == 0);
      oh = ($urandom_range(0, 11) == 0);
      oc = ($urandom_range(0, 11) == 0);
      ch = $urandom_range(0, 1);
      cl = ($urandom_range(0, 5) == 0);
      uv_logic = ul; uv_drive = ud; vout_low = ol; vout_high = oh; ocp = oc;
      comp_start = ch; comp_dis = cl; xdly_done = $urandom_range(0, 1);
      tick(6);
      fexp = exp_fault(fexp, puv, ul | ud, oh, oc);
      puv = ul | ud;
      eq("R3 R4 random latch", gate_low, fexp);
      if (ul | ud) eq("R2 random pg", pg_pull, 1);
      if (ol | oh) eq("R7 random window", pg_pull, 1);
      if (cl | fexp) eq("R6 random sw_en", sw_en, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule